// File: doc/BRIEF.md
# Interlaced Packed-Pixel Plotter

The plotter takes one pixel draw command at a time and updates a byte-wide video memory with a read-modify-write. Each command carries an x and y position, a colour value and a depth select. The block turns the position into a byte address and a bit mask, reads the byte, replaces only the bits that belong to the pixel, and writes the byte back. All other bits of that byte stay as they were.

The frame is interlaced across two 8 KB banks. Even scan lines go to the lower bank and odd scan lines to the upper bank. Each bank line is 80 bytes. Two pixel depths are supported: one bit per pixel at 640x200, and two bits per pixel at 320x200. Both fill 16000 bytes. Inside a byte, pixels are numbered from the most significant bit down. Commands enter through a valid/ready handshake. The memory side is a plain synchronous port with one cycle of read latency.

Top module: `ilace_plotter`

## Requirements
- R1: For an even y, the byte address is 80*(y/2) plus the byte offset within the line. Every address written stays below 8000 within its bank.
- R2: For an odd y, the byte address is 0x2000 + 80*(y/2) plus the byte offset, so bit 13 of the address equals bit 0 of y.
- R3: With cmd_mode = 0 (one bit per pixel), the byte offset is x/8. Bit 7-(x mod 8) of the written byte takes cmd_color[0], and every other bit keeps the value that was read.
- R4: With cmd_mode = 1 (two bits per pixel), the byte offset is x/4. Bits [7-2k : 6-2k] of the written byte take cmd_color[1:0], where k = x mod 4, and every other bit keeps the value that was read.
- R5: In one-bit mode cmd_color[1] has no effect. A colour of 2 clears the pixel bit and a colour of 3 sets it.
- R6: A command is out of range when y >= 200, or when x >= 640 in mode 0, or when x >= 320 in mode 1. Such a command is accepted and dropped. It makes no memory write and no read phase. err_pulse is high for exactly the one cycle after acceptance, and cmd_ready stays high.
- R7: A valid in-range command is accepted on a clock edge where cmd_valid and cmd_ready are both high. mem_addr holds the target address from the next cycle until the write completes. mem_we is high for exactly one cycle, the third cycle after acceptance. cmd_ready is low from the cycle after acceptance through the write cycle and high again right after it.
- R8: While rst is high and right after it, cmd_ready is high and mem_we and err_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Draw command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_x | input | 10 | Pixel column |
| cmd_y | input | 8 | Pixel row (scan line) |
| cmd_color | input | 2 | Pixel colour; low bit only in mode 0 |
| cmd_mode | input | 1 | 0 = one bit per pixel, 1 = two bits per pixel |
| err_pulse | output | 1 | One-cycle flag for a dropped out-of-range command |
| mem_addr | output | 14 | Video memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable |

## Verification
A wrong sequencer state shows within one cycle as a cmd_ready or mem_we level that differs from the expected four-cycle pattern, because the bench model predicts both on every clock. A wrong address or shift amount shows in the READ cycle as a mismatch on mem_addr, one cycle after acceptance. A wrong mask or merge shows in the write cycle as a mismatch on mem_wdata, and it is caught again by the final compare of all touched bytes. A faulty range check shows in the cycle after acceptance, either as a missing err_pulse or as a read phase that should not have started.

// File: rtl/plot_pkg.sv
package plot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2,
    ST_WRITE = 2'd3
  } plot_state_t;

  typedef enum logic {
    DEPTH_1BPP = 1'b0,
    DEPTH_2BPP = 1'b1
  } pix_depth_t;
endpackage

// File: rtl/plot_range_chk.sv
module plot_range_chk #(
  parameter int X_W        = 10,
  parameter int Y_W        = 8,
  parameter int MONO_COLS  = 640,
  parameter int COLOR_COLS = 320,
  parameter int ROWS       = 200
) (
  input  logic [X_W-1:0] x,
  input  logic [Y_W-1:0] y,
  input  logic           depth2,
  output logic           in_range
);
  localparam logic [X_W-1:0] X_LIM_1 = X_W'(MONO_COLS);
  localparam logic [X_W-1:0] X_LIM_2 = X_W'(COLOR_COLS);
  localparam logic [Y_W-1:0] Y_LIM   = Y_W'(ROWS);

  always_comb begin
    in_range = (y < Y_LIM) && (depth2 ? (x < X_LIM_2) : (x < X_LIM_1));
  end
endmodule

// File: rtl/plot_addr_gen.sv
module plot_addr_gen #(
  parameter int X_W         = 10,
  parameter int Y_W         = 8,
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 8,
  parameter int LINE_BYTES  = 80,
  parameter int BANK_OFFSET = 'h2000
) (
  input  logic [X_W-1:0]    x,
  input  logic [Y_W-1:0]    y,
  input  logic              depth2,
  input  logic [1:0]        color,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] bits
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] TOP1 = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] TOP2 = DATA_W'(3) << (DATA_W - 2);

  logic [ADDR_W-1:0] line_base;
  logic [ADDR_W-1:0] bank_base;
  logic [ADDR_W-1:0] byte_off;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] field;

  always_comb begin
    line_base = ADDR_W'(y >> 1) * ADDR_W'(LINE_BYTES);
    bank_base = y[0] ? ADDR_W'(BANK_OFFSET) : '0;
    byte_off  = depth2 ? ADDR_W'(x >> 2) : ADDR_W'(x >> 3);
    addr      = bank_base + line_base + byte_off;
    shamt     = depth2 ? SH_W'({x[1:0], 1'b0}) : x[SH_W-1:0];
    field     = depth2 ? (DATA_W'(color) << (DATA_W - 2))
                       : (DATA_W'(color[0]) << (DATA_W - 1));
    mask      = (depth2 ? TOP2 : TOP1) >> shamt;
    bits      = field >> shamt;
  end
endmodule

// File: rtl/plot_byte_merge.sv
module plot_byte_merge #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] old_byte,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] bits,
  output logic [DATA_W-1:0] new_byte
);
  always_comb begin
    new_byte = (old_byte & ~mask) | (bits & mask);
  end
endmodule

// File: rtl/ilace_plotter.sv
module ilace_plotter #(
  parameter int X_W         = 10,
  parameter int Y_W         = 8,
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 8,
  parameter int LINE_BYTES  = 80,
  parameter int BANK_OFFSET = 'h2000,
  parameter int MONO_COLS   = 640,
  parameter int COLOR_COLS  = 320,
  parameter int ROWS        = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [X_W-1:0]    cmd_x,
  input  logic [Y_W-1:0]    cmd_y,
  input  logic [1:0]        cmd_color,
  input  logic              cmd_mode,
  output logic              err_pulse,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);
  import plot_pkg::*;

  plot_state_t       state;
  pix_depth_t        depth;
  logic              in_range;
  logic [ADDR_W-1:0] addr_c;
  logic [DATA_W-1:0] mask_c, bits_c, merged_c;
  logic [DATA_W-1:0] mask_q, bits_q;

  assign depth = pix_depth_t'(cmd_mode);

  plot_range_chk #(
    .X_W(X_W), .Y_W(Y_W), .MONO_COLS(MONO_COLS),
    .COLOR_COLS(COLOR_COLS), .ROWS(ROWS)
  ) u_range (
    .x(cmd_x), .y(cmd_y), .depth2(depth == DEPTH_2BPP), .in_range(in_range)
  );

  plot_addr_gen #(
    .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LINE_BYTES(LINE_BYTES), .BANK_OFFSET(BANK_OFFSET)
  ) u_addr (
    .x(cmd_x), .y(cmd_y), .depth2(depth == DEPTH_2BPP), .color(cmd_color),
    .addr(addr_c), .mask(mask_c), .bits(bits_c)
  );

  plot_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .old_byte(mem_rdata), .mask(mask_q), .bits(bits_q), .new_byte(merged_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_ready <= 1'b1;
      err_pulse <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mask_q    <= '0;
      bits_q    <= '0;
    end else begin
      err_pulse <= 1'b0;
      mem_we    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid && cmd_ready) begin
            if (in_range) begin
              mem_addr  <= addr_c;
              mask_q    <= mask_c;
              bits_q    <= bits_c;
              cmd_ready <= 1'b0;
              state     <= ST_READ;
            end else begin
              err_pulse <= 1'b1;
            end
          end
        end
        ST_READ:  state <= ST_MERGE;
        ST_MERGE: begin
          mem_wdata <= merged_c;
          mem_we    <= 1'b1;
          state     <= ST_WRITE;
        end
        ST_WRITE: begin
          cmd_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/plot_checker.sv
module plot_checker #(
  parameter int ADDR_W      = 14,
  parameter int Y_W         = 8,
  parameter int LINE_BYTES  = 80,
  parameter int BANK_OFFSET = 'h2000,
  parameter int ROWS        = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [Y_W-1:0]    cmd_y,
  input logic              err_pulse,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we
);
  localparam int BANK_BIT = $clog2(BANK_OFFSET);
  localparam logic [BANK_BIT-1:0] BANK_LIMIT = BANK_BIT'(LINE_BYTES * (ROWS / 2));

  logic cap_odd;
  always_ff @(posedge clk) begin
    if (rst) cap_odd <= 1'b0;
    else if (cmd_valid && cmd_ready) cap_odd <= cmd_y[0];
  end

  assert_we_single_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  assert_busy_while_write_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !cmd_ready);
  assert_ready_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> cmd_ready);
  assert_addr_held_R7: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ready && $past(!cmd_ready)) |-> $stable(mem_addr));
  assert_drop_keeps_ready_R6: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (cmd_ready && !mem_we));
  assert_bank_select_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[BANK_BIT] == cap_odd));
  assert_bank_limit_R1: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[BANK_BIT-1:0] < BANK_LIMIT));
  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (cmd_ready && !mem_we && !err_pulse));
endmodule

bind ilace_plotter plot_checker #(
  .ADDR_W(ADDR_W), .Y_W(Y_W), .LINE_BYTES(LINE_BYTES),
  .BANK_OFFSET(BANK_OFFSET), .ROWS(ROWS)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_y(cmd_y), .err_pulse(err_pulse), .mem_addr(mem_addr), .mem_we(mem_we)
);

// File: tb/ilace_plotter_bench.sv
`timescale 1ns/1ps
module ilace_plotter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [9:0] cmd_x = '0;
  logic [7:0] cmd_y = '0;
  logic [1:0] cmd_color = '0;
  logic       cmd_mode = 1'b0;
  logic       err_pulse;
  logic [13:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic [7:0] mem_wdata;
  logic       mem_we;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ilace_plotter u_ilace_plotter (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_color(cmd_color), .cmd_mode(cmd_mode),
    .err_pulse(err_pulse), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  // Video memory and an independent expected image
  logic [7:0] vram [int];
  int         ref_mem [int];

  function automatic int init_byte(int a);
    return (a * 37 + 11) & 255;
  endfunction
  function automatic int vram_rd(int a);
    return vram.exists(a) ? int'(vram[a]) : init_byte(a);
  endfunction
  function automatic int ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_byte(a);
  endfunction

  always @(posedge clk) begin
    mem_rdata <= 8'(vram_rd(int'(mem_addr)));
    if (mem_we) vram[int'(mem_addr)] = mem_wdata;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle reference model
  int m_phase = 0;
  bit m_ready = 1, m_err = 0, m_we = 0, m_two = 0;
  int m_addr = 0, m_wdata = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_ready = 1; m_err = 0; m_we = 0;
    end else begin
      m_err = 0;
      m_we  = 0;
      case (m_phase)
        0: if (cmd_valid && m_ready) begin
          int x, y, c, pos, wid, lim, old, msk;
          x = int'(cmd_x); y = int'(cmd_y); c = int'(cmd_color);
          m_two = cmd_mode;
          lim = m_two ? 320 : 640;
          if (x >= lim || y >= 200) m_err = 1;
          else begin
            m_addr = 'h2000 * (y % 2) + 80 * (y / 2) + (m_two ? x / 4 : x / 8);
            wid = m_two ? 2 : 1;
            pos = m_two ? 6 - 2 * (x % 4) : 7 - (x % 8);
            msk = ((1 << wid) - 1) << pos;
            old = ref_rd(m_addr);
            m_wdata = (old & ~msk & 255) | ((c & ((1 << wid) - 1)) << pos);
            ref_mem[m_addr] = m_wdata;
            m_ready = 0;
            m_phase = 1;
          end
        end
        1: m_phase = 2;
        2: begin m_phase = 3; m_we = 1; end
        default: begin m_phase = 0; m_ready = 1; end
      endcase
    end
  end

  always @(negedge clk) begin
    chk(rst ? "R8 ready" : "R7 ready", int'(cmd_ready), int'(m_ready));
    chk(rst ? "R8 we" : "R7 we", int'(mem_we), int'(m_we));
    chk(rst ? "R8 err" : "R6 err", int'(err_pulse), int'(m_err));
    if (!rst && m_phase != 0)
      chk((m_addr >= 'h2000) ? "R2 addr" : "R1 addr", int'(mem_addr), m_addr);
    if (!rst && m_we)
      chk(m_two ? "R4 wdata" : "R3 wdata", int'(mem_wdata), m_wdata);
  end

  task automatic draw(int x, int y, int c, int mode);
    @(negedge clk);
    cmd_x = 10'(x); cmd_y = 8'(y); cmd_color = 2'(c); cmd_mode = mode[0];
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 / R3: even line, mono, corners of the byte
    draw(0, 0, 1, 0);
    draw(7, 0, 1, 0);
    draw(639, 198, 1, 0);
    // R2: odd lines, both depths
    draw(9, 1, 0, 0);
    draw(639, 199, 1, 0);
    draw(319, 199, 3, 1);
    // R4: each 2-bit slot
    draw(4, 2, 1, 1);
    draw(5, 2, 2, 1);
    draw(6, 2, 3, 1);
    draw(7, 2, 0, 1);
    settle();
    chk("R4 byte", vram_rd(80 + 1), ref_rd(80 + 1));
    // R5: upper colour bit ignored in mono
    draw(3, 4, 3, 0);
    draw(3, 4, 2, 0);
    settle();
    chk("R5 cleared", (vram_rd(160) >> 4) & 1, 0);
    draw(11, 4, 2, 0);
    draw(12, 4, 3, 0);
    settle();
    chk("R5 byte", vram_rd(161), ref_rd(161));
    // R6: out of range, back to back
    draw(640, 10, 1, 0);
    draw(320, 10, 1, 1);
    draw(0, 200, 1, 0);
    draw(5, 255, 3, 1);
    draw(639, 199, 0, 0);
    settle();
    chk("R6 untouched", vram_rd(80 * 5), init_byte(80 * 5));
    // Mixed traffic with gaps
    for (int i = 0; i < 300; i++) begin
      draw($urandom_range(0, 700), $urandom_range(0, 215),
           $urandom_range(0, 3), $urandom_range(0, 1));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    settle();
    foreach (ref_mem[a]) chk("R3/R4 image", vram_rd(a), ref_mem[a]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule